// File: doc/BRIEF.md
# Conversion Result Validity Tracker

This block sits on the host side of a sigma-delta converter whose digital filter needs several conversion periods to settle. It watches the converter's active-low data-ready line and a set of event pulses raised by the host whenever it changes something that disturbs the filter: an input step, a channel change, a sensor current source toggle, one of three calibration kinds, a coefficient write or an output rate change. For each event it loads the number of conversions that must be thrown away. It raises a result-valid flag and a one-cycle ready-to-read strobe only when a conversion arrives with that count at zero.

The host can shorten any wait by asking for a filter-reset sync. The block then drives a sync pulse of a set width to the converter and clears the pending discard count, so the first conversion after the pulse is trusted. A configuration input tells the tracker that the converter's sync and frame lines are tied together. In that wiring the converter no longer holds data-ready high during calibration, so the tracker has to discard the calibration-period strobes by counting them.

Top module: `vt_validity_tracker`

## Requirements
- R1: After reset, `result_valid`, `rdy_pulse` and `sync_out` are low and no discard is pending, so the first data-ready falling edge is treated as a valid result.
- R2: A data-ready falling edge counts as one conversion. An input step (`evt` bit 0), a current-source toggle (bit 2), a coefficient write (bit 6) or a rate change (bit 7) discards the next 3 conversions, and the 4th conversion is the first valid one.
- R3: A channel switch (`evt` bit 1) clears `result_valid`. The very next conversion is valid, because the converter itself withholds data-ready until the new channel has settled.
- R4: Self-calibration or system offset calibration (`evt` bit 3) and full system calibration (`evt` bit 4) discard nothing when `cfg_tied` is low. When `cfg_tied` is high they discard 9 and 6 conversions respectively.
- R5: Background calibration (`evt` bit 5) discards 1 conversion when `cfg_tied` is low and 7 conversions when `cfg_tied` is high.
- R6: An event that arrives while conversions are still pending sets the pending count to the larger of the remaining count and the event's own count. When several event bits are set at once, the largest of their counts applies.
- R7: A `sync_req` pulse while idle drives `sync_out` high for exactly max(SYNC_W, 2) clock cycles, starting in the cycle after the request is sampled.
- R8: Starting a sync clears the pending count and `result_valid`. Data-ready edges seen while `sync_out` is high are ignored, and the first conversion after the pulse is valid.
- R9: A `sync_req` that arrives while `sync_out` is already high is ignored and neither extends nor restarts the pulse.
- R10: Every valid conversion gives exactly one single-cycle `rdy_pulse`, and invalid conversions give none. `result_valid` stays high over later valid conversions until an event or a sync clears it.
- R11: Any event pulse clears `result_valid` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| drdy_n | input | 1 | Converter data-ready, active low, asynchronous to `clk` |
| evt | input | 8 | One-cycle event pulses, bit meanings as in R2 to R5 |
| sync_req | input | 1 | One-cycle request for a filter-reset sync |
| cfg_tied | input | 1 | High when the converter's sync and frame lines are tied together |
| sync_out | output | 1 | Filter-reset sync pulse to the converter |
| result_valid | output | 1 | Last conversion result is settled and usable |
| rdy_pulse | output | 1 | One-cycle strobe for each valid conversion |

## Verification
The bench targets overlapping events. A tracker that reloads instead of taking the maximum would release data too early after a short event follows a long one. It runs both wiring modes through the calibration events, because a design that ignores `cfg_tied` passes untied calibrations yet releases the first strobe after a tied nine-period calibration. It drives a data-ready edge inside a sync pulse, which a careless design would count and so flag a result from a half-reset filter as valid. It also repeats a sync request during an active pulse to catch a generator that stretches or restarts the pulse.

// File: rtl/vt_pkg.sv
package vt_pkg;

  localparam int EVT_N = 8;

  typedef enum int unsigned {
    EV_STEP    = 0,
    EV_CHAN    = 1,
    EV_ISRC    = 2,
    EV_SELFCAL = 3,
    EV_SYSCAL  = 4,
    EV_BGCAL   = 5,
    EV_COEF    = 6,
    EV_RATE    = 7
  } ev_idx_e;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Conversions to throw away after one event kind.
  function automatic int unsigned discard_for(
    input int unsigned idx, input logic tied,
    input int unsigned settle, input int unsigned selfcal,
    input int unsigned syscal, input int unsigned bgcal);
    int unsigned r;
    case (idx)
      EV_STEP, EV_ISRC, EV_COEF, EV_RATE: r = settle;
      EV_CHAN:    r = 0;
      EV_SELFCAL: r = tied ? selfcal : 0;
      EV_SYSCAL:  r = tied ? syscal : 0;
      EV_BGCAL:   r = tied ? (syscal + bgcal) : bgcal;
      default:    r = 0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/vt_drdy_edge.sv
module vt_drdy_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic drdy_n,
  output logic strobe
);
  localparam int LEN = STAGES + 1;

  logic [LEN-1:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '1;
    else        q <= {q[LEN-2:0], drdy_n};
  end

  // High for one cycle after the synchronised line falls.
  assign strobe = q[LEN-1] & ~q[LEN-2];

  assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);
endmodule

// File: rtl/vt_event_decode.sv
module vt_event_decode
  import vt_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int D_SETTLE  = 3,
  parameter int D_SELFCAL = 9,
  parameter int D_SYSCAL  = 6,
  parameter int D_BGCAL   = 1
) (
  input  logic [EVT_N-1:0] evt,
  input  logic             tied,
  output logic             evt_any,
  output logic [CNT_W-1:0] load
);
  always_comb begin
    int unsigned best;
    best = 0;
    for (int i = 0; i < EVT_N; i++) begin
      if (evt[i])
        best = umax(best, discard_for(i, tied, D_SETTLE, D_SELFCAL, D_SYSCAL, D_BGCAL));
    end
    load = CNT_W'(best);
  end

  assign evt_any = |evt;
endmodule

// File: rtl/vt_sync_gen.sv
module vt_sync_gen #(
  parameter int SYNC_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_req,
  output logic sync_start,
  output logic sync_out
);
  localparam int SYNC_LEN = (SYNC_W < 2) ? 2 : SYNC_W;
  localparam int SW_W     = $clog2(SYNC_LEN + 1);

  logic [SW_W-1:0] left;

  assign sync_start = sync_req & ~sync_out;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_out <= 1'b0;
      left     <= '0;
    end else if (sync_start) begin
      sync_out <= 1'b1;
      left     <= SW_W'(SYNC_LEN - 1);
    end else if (sync_out) begin
      if (left == '0) sync_out <= 1'b0;
      else            left     <= left - 1'b1;
    end
  end

  assert_sync_min_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_out) |=> sync_out);
  assert_sync_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_out) |-> $past(sync_req));
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_out && sync_req) |-> !sync_start);
endmodule

// File: rtl/vt_discard_ctr.sv
module vt_discard_ctr
  import vt_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic             evt_any,
  input  logic [CNT_W-1:0] load,
  input  logic             sync_start,
  input  logic             sync_busy,
  output logic             result_valid,
  output logic             rdy_pulse
);
  logic [CNT_W-1:0] cnt;
  logic             take;

  // A strobe that coincides with an event, a sync start or an active
  // sync pulse is not counted.
  assign take = strobe & ~sync_busy & ~sync_start & ~evt_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt          <= '0;
      result_valid <= 1'b0;
      rdy_pulse    <= 1'b0;
    end else begin
      rdy_pulse <= 1'b0;
      if (evt_any) begin
        cnt          <= sync_start ? load : CNT_W'(umax(cnt, load));
        result_valid <= 1'b0;
      end else if (sync_start) begin
        cnt          <= '0;
        result_valid <= 1'b0;
      end else if (take) begin
        if (cnt == '0) begin
          result_valid <= 1'b1;
          rdy_pulse    <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assert_evt_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    evt_any |=> !result_valid);
  assert_reload_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_any && !sync_start) |=> (cnt >= $past(load)) && (cnt >= $past(cnt)));
  assert_no_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_any |=> cnt <= $past(cnt));
  assert_sync_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_start && !evt_any) |=> (cnt == '0) && !result_valid);
  assert_rdy_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_pulse |-> result_valid);
  assert_busy_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_busy && !evt_any) |=> !rdy_pulse);
endmodule

// File: rtl/vt_validity_tracker.sv
module vt_validity_tracker
  import vt_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int SYNC_W      = 4,
  parameter int DRDY_STAGES = 2,
  parameter int D_SETTLE    = 3,
  parameter int D_SELFCAL   = 9,
  parameter int D_SYSCAL    = 6,
  parameter int D_BGCAL     = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drdy_n,
  input  logic [EVT_N-1:0] evt,
  input  logic             sync_req,
  input  logic             cfg_tied,
  output logic             sync_out,
  output logic             result_valid,
  output logic             rdy_pulse
);
  logic             strobe;
  logic             evt_any;
  logic [CNT_W-1:0] load;
  logic             sync_start;

  vt_drdy_edge #(.STAGES(DRDY_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .drdy_n(drdy_n), .strobe(strobe)
  );

  vt_event_decode #(
    .CNT_W(CNT_W), .D_SETTLE(D_SETTLE), .D_SELFCAL(D_SELFCAL),
    .D_SYSCAL(D_SYSCAL), .D_BGCAL(D_BGCAL)
  ) u_dec (
    .evt(evt), .tied(cfg_tied), .evt_any(evt_any), .load(load)
  );

  vt_sync_gen #(.SYNC_W(SYNC_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .sync_req(sync_req),
    .sync_start(sync_start), .sync_out(sync_out)
  );

  vt_discard_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .evt_any(evt_any),
    .load(load), .sync_start(sync_start), .sync_busy(sync_out),
    .result_valid(result_valid), .rdy_pulse(rdy_pulse)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> !result_valid && !rdy_pulse && !sync_out);
endmodule

// File: tb/test_vt_validity_tracker.sv
module test_vt_validity_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC_LEN   = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       drdy_n = 1'b1;
  logic [7:0] evt = '0;
  logic       sync_req = 1'b0;
  logic       cfg_tied = 1'b0;
  logic       sync_out, result_valid, rdy_pulse;

  int checks = 0, fails = 0;
  int rdy_seen = 0, sync_run = 0, last_w = 0, sync_pulses = 0;
  int exp_cnt = 0, exp_rdy = 0;
  bit exp_valid = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vt_validity_tracker i_vt_validity_tracker (
    .clk(clk), .rst_n(rst_n), .drdy_n(drdy_n), .evt(evt),
    .sync_req(sync_req), .cfg_tied(cfg_tied), .sync_out(sync_out),
    .result_valid(result_valid), .rdy_pulse(rdy_pulse)
  );

  always @(negedge clk) begin
    if (rdy_pulse) rdy_seen++;
    if (sync_out) sync_run++;
    else begin
      if (sync_run != 0) begin last_w = sync_run; sync_pulses++; end
      sync_run = 0;
    end
  end

  function automatic int bdisc(int i, bit tied);
    case (i)
      1: return 0;
      3: return tied ? 9 : 0;
      4: return tied ? 6 : 0;
      5: return tied ? 7 : 1;
      default: return 3;
    endcase
  endfunction

  function automatic int mask_disc(logic [7:0] m, bit tied);
    int r = 0;
    for (int i = 0; i < 8; i++) if (m[i] && bdisc(i, tied) > r) r = bdisc(i, tied);
    return r;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_state(string req);
    check(result_valid == exp_valid, req, result_valid, exp_valid);
    check(rdy_seen == exp_rdy, req, rdy_seen, exp_rdy);
  endtask

  task automatic do_event(logic [7:0] m);
    @(negedge clk) evt = m;
    @(negedge clk) evt = '0;
    step(1);
    if (mask_disc(m, cfg_tied) > exp_cnt) exp_cnt = mask_disc(m, cfg_tied);
    exp_valid = 0;
  endtask

  task automatic do_strobe();
    @(negedge clk) drdy_n = 1'b0;
    step(4);
    drdy_n = 1'b1;
    step(4);
    if (exp_cnt == 0) begin exp_valid = 1; exp_rdy++; end
    else exp_cnt--;
  endtask

  task automatic do_sync();
    @(negedge clk) sync_req = 1'b1;
    @(negedge clk) sync_req = 1'b0;
    step(SYNC_LEN + 3);
    exp_cnt = 0;
    exp_valid = 0;
  endtask

  // Runs n strobes; all but the last are expected invalid.
  task automatic strobes_until_valid(int n, string req);
    for (int k = 0; k < n - 1; k++) begin
      do_strobe();
      check(result_valid == 1'b0, req, result_valid, 0);
    end
    do_strobe();
    check(result_valid == 1'b1, req, result_valid, 1);
    check_state(req);
  endtask

  initial begin
    int p;
    p = $urandom(32'd20240611);
    step(3);
    check(result_valid == 0 && rdy_pulse == 0 && sync_out == 0, "R1", result_valid, 0);
    rst_n = 1'b1;
    step(2);
    do_strobe();
    check_state("R1");

    // R2: settle-type events, each 3 discards
    do_event(8'h01); strobes_until_valid(4, "R2");
    do_event(8'h04); strobes_until_valid(4, "R2");
    do_event(8'h40); strobes_until_valid(4, "R2");
    do_event(8'h80); strobes_until_valid(4, "R2");
    // R3/R11: channel switch clears valid, next strobe valid
    do_event(8'h02);
    check(result_valid == 1'b0, "R11", result_valid, 0);
    strobes_until_valid(1, "R3");
    // R4/R5 untied
    do_event(8'h08); strobes_until_valid(1, "R4");
    do_event(8'h10); strobes_until_valid(1, "R4");
    do_event(8'h20); strobes_until_valid(2, "R5");
    // R4/R5 tied
    cfg_tied = 1'b1;
    do_event(8'h08); strobes_until_valid(10, "R4");
    do_event(8'h10); strobes_until_valid(7, "R4");
    do_event(8'h20); strobes_until_valid(8, "R5");
    // R6: long event, two strobes, then short event keeps remaining 7
    do_event(8'h08); do_strobe(); do_strobe();
    do_event(8'h01); strobes_until_valid(8, "R6");
    // R6: multiple bits at once take the largest
    do_event(8'h12); strobes_until_valid(7, "R6");
    cfg_tied = 1'b0;

    // R7: width, R8: sync clears pending
    do_event(8'h01);
    do_sync();
    check(last_w == SYNC_LEN, "R7", last_w, SYNC_LEN);
    check(sync_pulses == 1, "R7", sync_pulses, 1);
    strobes_until_valid(1, "R8");
    // R8: strobe during sync pulse is ignored
    @(negedge clk) sync_req = 1'b1;
    @(negedge clk) begin sync_req = 1'b0; drdy_n = 1'b0; end
    step(4); drdy_n = 1'b1; step(SYNC_LEN + 2);
    exp_cnt = 0; exp_valid = 0;
    check_state("R8");
    strobes_until_valid(1, "R8");
    // R9: repeated request during pulse
    @(negedge clk) sync_req = 1'b1;
    @(negedge clk) sync_req = 1'b0;
    @(negedge clk) sync_req = 1'b1;
    @(negedge clk) sync_req = 1'b0;
    step(SYNC_LEN + 3);
    exp_cnt = 0; exp_valid = 0;
    check(last_w == SYNC_LEN, "R9", last_w, SYNC_LEN);
    check(sync_pulses == 3, "R9", sync_pulses, 3);
    // R10: valid stays high across valid strobes
    do_strobe(); do_strobe(); do_strobe();
    check_state("R10");

    // Random mix
    for (int it = 0; it < 600; it++) begin
      int op;
      op = $urandom_range(0, 9);
      if (it == 300) cfg_tied = 1'b1;
      if (op < 5) do_strobe();
      else if (op < 7) do_event(8'(1 << $urandom_range(0, 7)));
      else if (op < 9) do_event(8'($urandom_range(1, 255)));
      else do_sync();
      check_state("R10");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule